// File: doc/BRIEF.md
# Receive Jitter Smoothing Buffer

This block is an elastic bit buffer placed between a recovered receive clock and a smoothed output clock. Both clocks exist as enable strobes inside one system clock. A write strobe pushes one received bit into a circular store. A digital phase accumulator raises a read strobe each time its phase wraps, and each read strobe takes out one bit in arrival order. The accumulator step is a nominal increment plus a correction taken from the fill error, which is the current fill minus half depth. The correction is right-shifted by an amount that depends on the bandwidth setting, so the shift sets how fast the output rate follows the input.

The depth is 32 or 64 bits. In E1 operation the slow (about 1.5 Hz) bandwidth always uses the 64-bit depth. In T1 operation the bandwidth is a single fixed value and the bandwidth select is ignored. When the fill comes within the guard distance of empty or full, the block switches to a wide tracking gain and reports this on an output. It goes back to the configured narrow gain as soon as the fill leaves that window. Enabling the block, or changing its effective depth, re-centres the pointers so the fill starts at half depth. This gives a nominal latency of half the depth.

Top module: `jbuf_top`

## Requirements
- R1: While reset is asserted and after it is released with `en` low: `fill` is 16, and `rd_stb`, `xrun` and `wide` are 0.
- R2: Bits accepted on `wr_stb` leave on `dout` in the order they arrived, one bit for each cycle in which `rd_stb` is 1. After each enable, the first depth/2 reads return 0.
- R3: The effective depth is 32 when `deep_sel`=0 and 64 when `deep_sel`=1. While `en` is low, `fill` equals half the effective depth from the clock edge after any select change.
- R4: A change of effective depth while enabled sets `fill` to the new half depth at the next clock edge. On the first enabled cycle, `fill` equals half depth.
- R5: With `e1_mode`=1 and `bw_low_sel`=1, the effective depth is 64 whatever `deep_sel` is. With `e1_mode`=0, `bw_low_sel` does not alter the depth.
- R6: With `e1_mode`=0, the timing of `rd_stb` does not depend on `bw_low_sel`. With `e1_mode`=1, the two `bw_low_sel` settings produce different `rd_stb` timing for the same write pattern.
- R7: While enabled, `wide` is 1 exactly when `fill` is at most 2 or at least depth-2. It is 0 otherwise and whenever `en` is low.
- R8: When the average write rate equals the nominal read rate (one bit per 4 clocks), `fill` stays within 4 of half depth.
- R9: A read strobe on an empty buffer returns `dout`=0 and sets `xrun`. A write on a full buffer with no read in the same cycle is dropped and sets `xrun`. `xrun` stays 1 while `en` stays 1.
- R10: While `en` is low, `rd_stb` stays 0, and `xrun` clears at the first clock edge with `en` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Enable; low holds the buffer re-centred and idle |
| e1_mode | input | 1 | 1 selects E1 operation, 0 selects T1 |
| bw_low_sel | input | 1 | In E1, 1 selects the slow bandwidth (forces depth 64) |
| deep_sel | input | 1 | 1 requests depth 64, 0 requests depth 32 |
| wr_stb | input | 1 | Write strobe of the recovered clock domain |
| din | input | 1 | Received bit, taken when `wr_stb` is 1 |
| rd_stb | output | 1 | Smoothed read strobe; `dout` is valid while it is 1 |
| dout | output | 1 | Bit read out of the buffer |
| fill | output | 7 | Number of bits held |
| wide | output | 1 | Wide tracking gain is active |
| xrun | output | 1 | Sticky flag for an overflow or underflow collision |

## Verification
Timing is counted from the rising edge that samples the stimulus. `fill` and `xrun` update at that edge, and `wide` follows combinationally from the registered fill. A read that the accumulator schedules at one edge shows up as `rd_stb` and `dout` one edge later. The bench changes inputs on falling edges and samples results 1 ns after a later falling edge, so each check lands one full edge after its cause. A scoreboard queue holds the expected bit sequence, including the half-depth zeros. A monitor compares each strobed bit against it, so the check does not depend on the exact cycle of any read.

// File: rtl/jbuf_pkg.sv
package jbuf_pkg;
   typedef enum logic [1:0] {
      BW_T1_FIXED = 2'd0,
      BW_E1_FAST  = 2'd1,
      BW_E1_SLOW  = 2'd2,
      BW_TRACK    = 2'd3
   } bw_mode_e;
endpackage

// File: rtl/jbuf_cfg.sv
module jbuf_cfg
   import jbuf_pkg::*;
(
   input  logic     e1_mode,
   input  logic     bw_low_sel,
   input  logic     deep_sel,
   input  logic     wide,
   output logic     deep_eff,
   output bw_mode_e bw
);
   logic slow_e1;

   assign slow_e1  = e1_mode & bw_low_sel;
   assign deep_eff = deep_sel | slow_e1;

   always_comb begin
      if (wide)          bw = BW_TRACK;
      else if (!e1_mode) bw = BW_T1_FIXED;
      else if (slow_e1)  bw = BW_E1_SLOW;
      else               bw = BW_E1_FAST;
   end
endmodule

// File: rtl/jbuf_store.sv
module jbuf_store #(
   parameter int MIN_DEPTH = 32,
   parameter int MAX_DEPTH = 64,
   parameter int GUARD     = 2,
   localparam int PW = $clog2(MAX_DEPTH),
   localparam int FW = $clog2(MAX_DEPTH + 1)
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic          deep_eff,
   input  logic          wr_stb,
   input  logic          din,
   input  logic          rd_tick,
   output logic          dout,
   output logic          rd_vld,
   output logic [FW-1:0] fill,
   output logic          deep_act,
   output logic          wide,
   output logic          xrun
);
   localparam logic [FW-1:0] D_MIN  = FW'(MIN_DEPTH);
   localparam logic [FW-1:0] D_MAX  = FW'(MAX_DEPTH);
   localparam logic [FW-1:0] H_MIN  = FW'(MIN_DEPTH / 2);
   localparam logic [FW-1:0] H_MAX  = FW'(MAX_DEPTH / 2);
   localparam logic [FW-1:0] G_LIM  = FW'(GUARD);

   if (MIN_DEPTH < 4 * GUARD + 4) begin : g_bad_guard
      $error("jbuf_store: MIN_DEPTH too small for GUARD");
   end
   if (MAX_DEPTH < MIN_DEPTH) begin : g_bad_depth
      $error("jbuf_store: MAX_DEPTH below MIN_DEPTH");
   end

   logic                 deep_q, dout_q, vld_q, xrun_q;
   logic [PW-1:0]        wptr_q, rptr_q;
   logic [FW-1:0]        fill_q, depth_cur, half_new;
   logic [MAX_DEPTH-1:0] mem_q;
   logic                 rec, empty, full, rd_ok, wr_ok, under, over;

   function automatic logic [PW-1:0] step_ptr(input logic [PW-1:0] p,
                                              input logic [FW-1:0] d);
      return ((FW'(p) + FW'(1)) == d) ? '0 : p + PW'(1);
   endfunction

   assign depth_cur = deep_q   ? D_MAX : D_MIN;
   assign half_new  = deep_eff ? H_MAX : H_MIN;
   assign rec       = !en || (deep_eff != deep_q);
   assign empty     = (fill_q == '0);
   assign full      = (fill_q == depth_cur);
   assign rd_ok     = rd_tick && !empty;
   assign wr_ok     = wr_stb && (!full || rd_ok);
   assign under     = rd_tick && empty;
   assign over      = wr_stb && full && !rd_ok;

   for (genvar i = 0; i < MAX_DEPTH; i++) begin : g_cell
      logic bit_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                              bit_q <= 1'b0;
         else if (rec)                            bit_q <= 1'b0;
         else if (wr_ok && (wptr_q == PW'(i)))    bit_q <= din;
      end
      assign mem_q[i] = bit_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         deep_q <= 1'b0;
         wptr_q <= PW'(H_MIN);
         rptr_q <= '0;
         fill_q <= H_MIN;
         dout_q <= 1'b0;
         vld_q  <= 1'b0;
         xrun_q <= 1'b0;
      end else if (rec) begin
         deep_q <= deep_eff;
         wptr_q <= PW'(half_new);
         rptr_q <= '0;
         fill_q <= half_new;
         dout_q <= 1'b0;
         vld_q  <= 1'b0;
         if (!en) xrun_q <= 1'b0;
      end else begin
         if (wr_ok) wptr_q <= step_ptr(wptr_q, depth_cur);
         if (rd_ok) rptr_q <= step_ptr(rptr_q, depth_cur);
         fill_q <= fill_q + FW'(wr_ok) - FW'(rd_ok);
         vld_q  <= rd_tick;
         dout_q <= rd_ok ? mem_q[rptr_q] : 1'b0;
         if (under || over) xrun_q <= 1'b1;
      end
   end

   assign wide     = en && ((fill_q <= G_LIM) || (fill_q >= depth_cur - G_LIM));
   assign fill     = fill_q;
   assign deep_act = deep_q;
   assign dout     = dout_q;
   assign rd_vld   = vld_q;
   assign xrun     = xrun_q;

   // R9: occupancy never exceeds the active depth
   a_r9_fill_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      fill_q <= depth_cur);
   // R9: a collision flag survives while enabled
   a_r9_xrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (xrun_q && en) |=> xrun_q);
   // R4: first enabled cycle starts centred
   a_r4_centred_on_enable: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(en) |-> (fill_q == (deep_q ? H_MAX : H_MIN)));
endmodule

// File: rtl/jbuf_nco.sv
module jbuf_nco
   import jbuf_pkg::*;
#(
   parameter int NCO_W      = 16,
   parameter int INC_NOM    = 16384,
   parameter int CORR_SCALE = 10,
   parameter int SH_T1      = 6,
   parameter int SH_E1_FAST = 5,
   parameter int SH_E1_SLOW = 8,
   parameter int SH_TRACK   = 2,
   parameter int MAX_DEPTH  = 64,
   localparam int FW = $clog2(MAX_DEPTH + 1),
   localparam int EW = FW + 1,
   localparam int CW = EW + CORR_SCALE,
   localparam int IW = NCO_W + 1
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  bw_mode_e      bw,
   input  logic [FW-1:0] fill,
   input  logic [FW-1:0] half,
   output logic          tick
);
   localparam longint MAX_CORR = (longint'(MAX_DEPTH / 2) << CORR_SCALE) >> SH_TRACK;

   if (longint'(INC_NOM) + MAX_CORR >= (64'd1 << (NCO_W - 1))) begin : g_bad_fast
      $error("jbuf_nco: peak step could strobe on adjacent cycles");
   end
   if (longint'(INC_NOM) - MAX_CORR <= 0) begin : g_bad_slow
      $error("jbuf_nco: minimum step not positive");
   end

   logic signed [EW-1:0] err;
   logic signed [CW-1:0] scaled, corr;
   logic [4:0]           sh;
   logic [IW-1:0]        inc, sum;
   logic [NCO_W-1:0]     acc_q;
   logic                 tick_q;

   assign err    = $signed({1'b0, fill}) - $signed({1'b0, half});
   assign scaled = CW'(err) <<< CORR_SCALE;

   always_comb begin
      unique case (bw)
         BW_TRACK:   sh = 5'(SH_TRACK);
         BW_E1_FAST: sh = 5'(SH_E1_FAST);
         BW_E1_SLOW: sh = 5'(SH_E1_SLOW);
         default:    sh = 5'(SH_T1);
      endcase
   end

   assign corr = scaled >>> sh;
   assign inc  = IW'(INC_NOM) + IW'(corr);
   assign sum  = {1'b0, acc_q} + inc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q  <= '0;
         tick_q <= 1'b0;
      end else if (!en) begin
         acc_q  <= '0;
         tick_q <= 1'b0;
      end else begin
         acc_q  <= sum[NCO_W-1:0];
         tick_q <= sum[NCO_W];
      end
   end

   assign tick = tick_q;

   // R8: the smoothed read rate never strobes on two cycles in a row
   a_r8_tick_spaced: assert property (@(posedge clk) disable iff (!rst_n)
      tick_q |=> !tick_q);
endmodule

// File: rtl/jbuf_top.sv
module jbuf_top
   import jbuf_pkg::*;
#(
   parameter int MIN_DEPTH  = 32,
   parameter int MAX_DEPTH  = 64,
   parameter int GUARD      = 2,
   parameter int NCO_W      = 16,
   parameter int INC_NOM    = 16384,
   parameter int CORR_SCALE = 10,
   parameter int SH_T1      = 6,
   parameter int SH_E1_FAST = 5,
   parameter int SH_E1_SLOW = 8,
   parameter int SH_TRACK   = 2
)(
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             en,
   input  logic                             e1_mode,
   input  logic                             bw_low_sel,
   input  logic                             deep_sel,
   input  logic                             wr_stb,
   input  logic                             din,
   output logic                             rd_stb,
   output logic                             dout,
   output logic [$clog2(MAX_DEPTH+1)-1:0]   fill,
   output logic                             wide,
   output logic                             xrun
);
   localparam int FW = $clog2(MAX_DEPTH + 1);

   bw_mode_e      bw;
   logic          deep_eff, deep_act, rd_tick;
   logic [FW-1:0] half_c;

   assign half_c = deep_act ? FW'(MAX_DEPTH / 2) : FW'(MIN_DEPTH / 2);

   jbuf_cfg u_cfg (
      .e1_mode    (e1_mode),
      .bw_low_sel (bw_low_sel),
      .deep_sel   (deep_sel),
      .wide       (wide),
      .deep_eff   (deep_eff),
      .bw         (bw)
   );

   jbuf_store #(
      .MIN_DEPTH (MIN_DEPTH),
      .MAX_DEPTH (MAX_DEPTH),
      .GUARD     (GUARD)
   ) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (en),
      .deep_eff (deep_eff),
      .wr_stb   (wr_stb),
      .din      (din),
      .rd_tick  (rd_tick),
      .dout     (dout),
      .rd_vld   (rd_stb),
      .fill     (fill),
      .deep_act (deep_act),
      .wide     (wide),
      .xrun     (xrun)
   );

   jbuf_nco #(
      .NCO_W      (NCO_W),
      .INC_NOM    (INC_NOM),
      .CORR_SCALE (CORR_SCALE),
      .SH_T1      (SH_T1),
      .SH_E1_FAST (SH_E1_FAST),
      .SH_E1_SLOW (SH_E1_SLOW),
      .SH_TRACK   (SH_TRACK),
      .MAX_DEPTH  (MAX_DEPTH)
   ) u_nco (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (en),
      .bw    (bw),
      .fill  (fill),
      .half  (half_c),
      .tick  (rd_tick)
   );

   // R5: slow E1 bandwidth lands on the deep store one edge later
   a_r5_slow_forces_deep: assert property (@(posedge clk) disable iff (!rst_n)
      (en && e1_mode && bw_low_sel) |=> deep_act);
endmodule

// File: tb/jbuf_top_tb_top.sv
module jbuf_top_tb_top;
   logic       clk = 1'b0;
   logic       rst_n, en, e1_mode, bw_low_sel, deep_sel, wr_stb, din;
   logic       rd_stb, dout, wide, xrun;
   logic [6:0] fill;

   int  total = 0, bad = 0, reads = 0, dcur = 32;
   bit  sb_on = 0, wchk_on = 0, sig_on = 0, wide_seen = 0;
   int  cyc = 0;
   longint sig = 0;
   bit  sb_q[$];
   logic [15:0] lfsr = 16'hACE1;

   always #4 clk = ~clk;

   jbuf_top dut_i (
      .clk(clk), .rst_n(rst_n), .en(en), .e1_mode(e1_mode),
      .bw_low_sel(bw_low_sel), .deep_sel(deep_sel), .wr_stb(wr_stb), .din(din),
      .rd_stb(rd_stb), .dout(dout), .fill(fill), .wide(wide), .xrun(xrun)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr_bit(input bit b);
      din = b; wr_stb = 1'b1;
      if (sb_on) sb_q.push_back(b);
      @(negedge clk);
      wr_stb = 1'b0;
   endtask

   function automatic bit next_bit();
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      return lfsr[0];
   endfunction

   // monitor: scoreboard pop, window check, strobe signature
   always @(negedge clk) begin
      #1;
      if (sb_on && rd_stb) begin
         reads++;
         if (sb_q.size() == 0) chk(1'b0, "R2 read with empty scoreboard", int'(dout), -1);
         else begin
            automatic bit e = sb_q.pop_front();
            chk(dout == e, "R2 data order", int'(dout), int'(e));
         end
      end
      if (wchk_on) begin
         automatic bit we = (int'(fill) <= 2) || (int'(fill) >= dcur - 2);
         chk(wide == we, "R7 danger window", int'(wide), int'(we));
         if (wide) wide_seen = 1;
      end
      if (sig_on) begin
         cyc++;
         if (rd_stb) sig += cyc;
      end
   end

   task automatic setup(input bit e1, input bit lo, input bit dp);
      wchk_on = 0; sb_on = 0;
      en = 0; e1_mode = e1; bw_low_sel = lo; deep_sel = dp;
      dcur = (dp || (e1 && lo)) ? 64 : 32;
      tick(3);
   endtask

   task automatic sb_run(input bit e1, input bit lo, input bit dp, input int words, input string tg);
      setup(e1, lo, dp);
      sb_q.delete(); reads = 0;
      for (int i = 0; i < dcur / 2; i++) sb_q.push_back(1'b0);
      en = 1; sb_on = 1; wchk_on = 1;
      for (int i = 0; i < words; i++) begin
         wr_bit(next_bit());
         tick((i % 2 == 0) ? 2 : 4);
      end
      #2;
      chk((int'(fill) >= dcur/2 - 4) && (int'(fill) <= dcur/2 + 4), {"R8 fill near centre ", tg}, int'(fill), dcur/2);
      chk(xrun == 1'b0, {"R9 no collision ", tg}, int'(xrun), 0);
      chk(wide_seen == 0, {"R7 wide stays low ", tg}, int'(wide_seen), 0);
      chk(reads > words / 2, {"R2 reads produced ", tg}, reads, words);
      sb_on = 0; wchk_on = 0;
      tick(1);
      en = 0;
      tick(2);
   endtask

   task automatic measure(input bit e1, input bit lo, input bit dp, input int words, output longint s);
      setup(e1, lo, dp);
      en = 1; sig = 0; cyc = 0; sig_on = 1;
      for (int i = 0; i < words; i++) begin
         wr_bit(1'b1);
         tick(2);
      end
      sig_on = 0; s = sig;
      en = 0; tick(2);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog expired act=%0d exp=%0d", 150000, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      longint s0, s1;
      int     n;
      rst_n = 0; en = 0; e1_mode = 0; bw_low_sel = 0; deep_sel = 0; wr_stb = 0; din = 0;
      tick(3);
      chk(fill == 7'd16, "R1 fill in reset", int'(fill), 16);
      chk(xrun == 1'b0 && rd_stb == 1'b0 && wide == 1'b0, "R1 flags in reset", int'({xrun, rd_stb, wide}), 0);
      rst_n = 1;
      tick(3);
      chk(fill == 7'd16 && rd_stb == 1'b0, "R1 idle after release", int'(fill), 16);

      // R3 depth selection while disabled
      deep_sel = 1; tick(1);
      chk(fill == 7'd32, "R3 deep select", int'(fill), 32);
      deep_sel = 0; tick(1);
      chk(fill == 7'd16, "R3 shallow select", int'(fill), 16);

      // R5 forcing of the deep store
      e1_mode = 1; bw_low_sel = 1; tick(1);
      chk(fill == 7'd32, "R5 E1 slow forces 64", int'(fill), 32);
      e1_mode = 0; tick(1);
      chk(fill == 7'd16, "R5 T1 ignores low select for depth", int'(fill), 16);
      bw_low_sel = 0;

      // R2 and R8 scoreboard runs in three configurations
      sb_run(1'b0, 1'b0, 1'b0, 400, "T1/32");
      sb_run(1'b1, 1'b0, 1'b1, 400, "E1fast/64");
      sb_run(1'b1, 1'b1, 1'b0, 400, "E1slow/forced64");

      // R4 recentring on enable and on depth change
      setup(1'b0, 1'b0, 1'b1);
      en = 1; tick(1);
      chk(fill == 7'd32, "R4 centred on enable", int'(fill), 32);
      for (int i = 0; i < 6; i++) wr_bit(1'b1);
      deep_sel = 0; tick(1);
      chk(fill == 7'd16, "R4 recentre on depth drop", int'(fill), 16);
      for (int i = 0; i < 6; i++) wr_bit(1'b1);
      deep_sel = 1; tick(1);
      chk(fill == 7'd32, "R4 recentre on depth rise", int'(fill), 32);
      en = 0; tick(2);

      // R6 bandwidth select: no effect in T1, effect in E1
      measure(1'b0, 1'b0, 1'b0, 50, s0);
      measure(1'b0, 1'b1, 1'b0, 50, s1);
      chk(s0 == s1, "R6 T1 strobe timing independent of low select", int'(s1), int'(s0));
      measure(1'b1, 1'b0, 1'b1, 100, s0);
      measure(1'b1, 1'b1, 1'b1, 100, s1);
      chk(s0 != s1, "R6 E1 bandwidth select changes strobe timing", int'(s1), int'(s0));

      // R9 underflow and R7 entry to wide mode
      setup(1'b0, 1'b0, 1'b0);
      wide_seen = 0; en = 1; wchk_on = 1;
      tick(300);
      chk(xrun == 1'b1, "R9 underflow sets xrun", int'(xrun), 1);
      chk(fill == 7'd0, "R9 empty after drain", int'(fill), 0);
      chk(wide_seen == 1, "R7 wide entered near empty", int'(wide_seen), 1);
      n = 0;
      while (!rd_stb && n < 20) begin tick(1); n++; end
      chk(rd_stb == 1'b1 && dout == 1'b0, "R9 empty read returns zero", int'({rd_stb, dout}), 2);
      wchk_on = 0;
      en = 0; tick(1);
      chk(xrun == 1'b0, "R10 xrun cleared when disabled", int'(xrun), 0);
      chk(wide == 1'b0, "R7 wide low when disabled", int'(wide), 0);
      n = 0;
      for (int i = 0; i < 20; i++) begin tick(1); if (rd_stb) n++; end
      chk(n == 0, "R10 no read strobes while disabled", n, 0);

      // R9 overflow
      setup(1'b1, 1'b0, 1'b1);
      wide_seen = 0; en = 1; wchk_on = 1;
      din = 1; wr_stb = 1;
      tick(120);
      wr_stb = 0;
      #2;
      chk(xrun == 1'b1, "R9 overflow sets xrun", int'(xrun), 1);
      chk(int'(fill) >= 62 && int'(fill) <= 64, "R9 fill capped at depth", int'(fill), 64);
      chk(wide_seen == 1, "R7 wide entered near full", int'(wide_seen), 1);
      tick(3);
      chk(xrun == 1'b1, "R9 xrun sticky while enabled", int'(xrun), 1);
      wchk_on = 0; en = 0; tick(2);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule